// File: doc/BRIEF.md
# Prescaled Up-Counting Time Base

This block is a time base for a general-purpose timer. A 16-bit up-counter advances once per tick. A 16-bit prescaler makes the ticks by dividing the system clock. The counter wraps to zero after it reaches the active wrap limit, and it reports each wrap with a one-cycle overflow pulse. The prescaler output is used as a clock enable, so the whole block runs in one clock domain.

Software writes the divider and the wrap limit into staging registers. An update event moves them into the active registers. An update event comes from an overflow or from a software restart strobe. Two control bits shape the update behaviour. One suppresses update events completely. The other keeps software restarts from raising the update flag. A sticky update flag, gated by an interrupt enable, produces the interrupt request.

Register map used by the write and read port (2-bit address): 0 = counter, 1 = divider staging value, 2 = wrap-limit staging value, 3 = status (bit 0 is the update flag).

Top module: `tick_timebase`

## Requirements
- R1: While ticks run and the wrap limit is nonzero, the counter rises by one per tick. In the cycle where a tick meets a count equal to the wrap limit, `overflow` and `updateEvt` are high for one cycle, the count is 0 in the following cycle, and the update flag is 1 in that following cycle.
- R2: Ticks occur once every (active divider + 1) clocks. A divider written at address 1 affects tick spacing only after the next update event.
- R3: With `arPreload` = 1, a value written at address 2 becomes the active wrap limit only at an update event. With `arPreload` = 0, it is active from the next cycle. A read of address 2 always returns the staging value.
- R4: While `updDisable` = 1, `updateEvt` stays low and the active registers keep their values. The counter still wraps at the active limit, and a restart strobe still clears the counter and the prescaler.
- R5: While `updSource` = 1, a restart strobe produces an update event that reloads the active registers but leaves the update flag unchanged. Overflow still sets the flag.
- R6: After `cntEnable` rises, the first tick comes one clock later, and the counter holds its value in the cycle where the enable rises.
- R7: After reset the counter is 0, the update flag is 0, the divider is 0 and the wrap limit reads 0xFFFF. While the active wrap limit is 0, the counter holds and no overflow occurs.
- R8: The update flag can be cleared only by writing a 0 to bit 0 at address 3. Writing a 1 leaves it set. `irq` is high exactly when the flag and `irqEnable` are both 1.
- R9: A restart strobe clears the counter and the prescaler in the next cycle. A strobe that coincides with an overflow produces a single update event.
- R10: A counter write at address 0 loads the value in the next cycle and takes priority over a tick in the same cycle.
- R11: Reading address 1 returns the divider staging value, and reading address 3 returns the update flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational |
| cntEnable | input | 1 | Counter enable |
| arPreload | input | 1 | Stage wrap-limit writes until an update |
| updDisable | input | 1 | Suppress update events |
| updSource | input | 1 | Only overflow may set the update flag |
| updGen | input | 1 | Software restart and update strobe, one cycle |
| irqEnable | input | 1 | Update interrupt enable |
| count | output | 16 | Counter value |
| tick | output | 1 | Prescaler clock enable for the counter |
| overflow | output | 1 | One-cycle wrap pulse |
| updateEvt | output | 1 | One-cycle update event |
| updFlag | output | 1 | Sticky update flag |
| irq | output | 1 | Update interrupt request |

## Verification
`tick`, `overflow` and `updateEvt` are combinational. They are due in the same cycle as the stimulus or state that causes them. The counter, the update flag and every active register change one edge after the event that moves them, and the enable adds one more register stage before the first tick. The prescaler counter is not a port, so the bench tracks its phase across each enable and disable, including the extra step it takes in the cycle the enable falls. Every expected item is queued with its due cycle number, and the monitor compares it in the window between the falling edge and the next rising edge, after the driven inputs have settled.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic tick;     // prescaler allows one count step
    logic wrap;     // count at limit on a tick
    logic update;   // reload active registers
    logic restart;  // software restart clears counter
  } tb_strobe_t;
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnable,
  input  logic             updDisable,
  input  logic             updSource,
  input  logic             updGen,
  input  logic             atTop,
  input  logic [PSC_W-1:0] pscLimit,
  input  logic             statWr,
  input  logic             statBit,
  output tb_strobe_t       strb,
  output logic             updFlag
);
  logic             enDly;
  logic [PSC_W-1:0] pscCnt;
  logic             tickNow, wrapNow, updNow, flagSet;

  always_comb begin
    tickNow = enDly && (pscCnt == pscLimit);
    wrapNow = tickNow && atTop;
    updNow  = !updDisable && (wrapNow || updGen);
    flagSet = updNow && (wrapNow || !updSource);
    strb.tick    = tickNow;
    strb.wrap    = wrapNow;
    strb.update  = updNow;
    strb.restart = updGen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enDly   <= 1'b0;
      pscCnt  <= '0;
      updFlag <= 1'b0;
    end else begin
      enDly <= cntEnable;
      if (updGen)
        pscCnt <= '0;
      else if (enDly)
        pscCnt <= tickNow ? '0 : pscCnt + 1'b1;
      if (flagSet)
        updFlag <= 1'b1;
      else if (statWr && !statBit)
        updFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tbase_dp.sv
module tbase_dp
  import tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tb_strobe_t        strb,
  input  logic              arPreload,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [PSC_W-1:0]  pscPre,
  output logic [PSC_W-1:0]  pscShadow,
  output logic [CNT_W-1:0]  arrPre,
  output logic              atTop
);
  logic [CNT_W-1:0] arrShadow;
  logic             limitZero;
  logic             cntWr, pscWr, arrWr;

  always_comb begin
    limitZero = (arrShadow == '0);
    atTop     = !limitZero && (count == arrShadow);
    cntWr     = wrEn && (wrAddr == ADDR_CNT);
    pscWr     = wrEn && (wrAddr == ADDR_PSC);
    arrWr     = wrEn && (wrAddr == ADDR_ARR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      pscPre    <= '0;
      pscShadow <= '0;
      arrPre    <= '1;
      arrShadow <= '1;
    end else begin
      if (strb.restart)
        count <= '0;
      else if (cntWr)
        count <= wrData[CNT_W-1:0];
      else if (strb.wrap)
        count <= '0;
      else if (strb.tick && !limitZero)
        count <= count + 1'b1;

      if (pscWr)
        pscPre <= wrData[PSC_W-1:0];
      if (strb.update)
        pscShadow <= pscPre;

      if (arrWr)
        arrPre <= wrData[CNT_W-1:0];
      if (arrWr && !arPreload)
        arrShadow <= wrData[CNT_W-1:0];
      else if (strb.update)
        arrShadow <= arrPre;
    end
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                                              clk,
  input  logic                                              rstN,
  input  logic                                              wrEn,
  input  logic [1:0]                                        wrAddr,
  input  logic [((CNT_W > PSC_W) ? CNT_W : PSC_W)-1:0]      wrData,
  input  logic [1:0]                                        rdAddr,
  output logic [((CNT_W > PSC_W) ? CNT_W : PSC_W)-1:0]      rdData,
  input  logic                                              cntEnable,
  input  logic                                              arPreload,
  input  logic                                              updDisable,
  input  logic                                              updSource,
  input  logic                                              updGen,
  input  logic                                              irqEnable,
  output logic [CNT_W-1:0]                                  count,
  output logic                                              tick,
  output logic                                              overflow,
  output logic                                              updateEvt,
  output logic                                              updFlag,
  output logic                                              irq
);
  localparam int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W;

  tb_strobe_t       strb;
  logic [PSC_W-1:0] pscPre, pscShadow;
  logic [CNT_W-1:0] arrPre;
  logic             atTop;
  logic             statWr;

  assign statWr = wrEn && (wrAddr == ADDR_STAT);

  tbase_ctrl #(.PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .updDisable(updDisable),
    .updSource(updSource), .updGen(updGen), .atTop(atTop), .pscLimit(pscShadow),
    .statWr(statWr), .statBit(wrData[0]), .strb(strb), .updFlag(updFlag)
  );

  tbase_dp #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .arPreload(arPreload), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .count(count), .pscPre(pscPre),
    .pscShadow(pscShadow), .arrPre(arrPre), .atTop(atTop)
  );

  assign tick      = strb.tick;
  assign overflow  = strb.wrap;
  assign updateEvt = strb.update;
  assign irq       = updFlag && irqEnable;

  always_comb begin
    case (rdAddr)
      ADDR_CNT: rdData = DATA_W'(count);
      ADDR_PSC: rdData = DATA_W'(pscPre);
      ADDR_ARR: rdData = DATA_W'(arrPre);
      default:  rdData = DATA_W'(updFlag);
    endcase
  end
endmodule

// File: rtl/tick_timebase_chk.sv
module tick_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEnable,
  input logic             updDisable,
  input logic             updGen,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             overflow,
  input logic             updateEvt,
  input logic             updFlag
);
  // R1: a wrap is followed by a zero count unless software loads the counter
  p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(wrEn && wrAddr == 2'd0)) |=> (count == '0));

  // R1: a wrap happens only on a prescaler tick
  p_ovf_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> tick);

  // R4: update suppression blocks every update event
  p_udis_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    updDisable |-> !updateEvt);

  // R6: no tick in the cycle the enable rises
  p_start_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cntEnable) |-> !tick);

  // R8: the flag rises only after an update event
  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> $past(updateEvt));

  // R9: a restart strobe clears the counter
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    updGen |=> (count == '0));

  // R9: an update event always has a cause
  p_evt_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |-> (overflow || updGen));
endmodule

bind tick_timebase tick_timebase_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tick_timebase.sv
module tb_tick_timebase;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        cntEnable = 1'b0, arPreload = 1'b0, updDisable = 1'b0;
  logic        updSource = 1'b0, updGen = 1'b0, irqEnable = 1'b0;
  logic [15:0] count;
  logic        tick, overflow, updateEvt, updFlag, irq;

  tick_timebase dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntEnable(cntEnable), .arPreload(arPreload),
    .updDisable(updDisable), .updSource(updSource), .updGen(updGen),
    .irqEnable(irqEnable), .count(count), .tick(tick), .overflow(overflow),
    .updateEvt(updateEvt), .updFlag(updFlag), .irq(irq)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int    due;
    int    kind;  // 0 count 1 overflow 2 updateEvt 3 updFlag 4 tick 5 irq 6 rdData
    int    val;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 1'b0;

  function automatic int sampleKind(int kind);
    case (kind)
      0: return int'(count);
      1: return int'(overflow);
      2: return int'(updateEvt);
      3: return int'(updFlag);
      4: return int'(tick);
      5: return int'(irq);
      default: return int'(rdData);
    endcase
  endfunction

  // driver side: queue an expectation due d windows from now
  task automatic expect_at(int d, int kind, int val, string tag);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic nxt();
    @(negedge clk);
    wrEn = 1'b0;
    updGen = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
  endtask

  // monitor: compares items in the settled part of each cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #3;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          int act;
          act = sampleKind(q[i].kind);
          nChecks++;
          if (act != q[i].val) begin
            nFails++;
            $display("FAIL %s kind %0d cycle %0d: actual 0x%0h expected 0x%0h",
                     q[i].tag, q[i].kind, cyc, act, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nxt();
    // R7 reset state
    rdAddr = 2'd2;
    expect_at(0, 0, 0, "R7");
    expect_at(0, 3, 0, "R7");
    expect_at(0, 6, 16'hFFFF, "R7");

    // R1/R3/R6: limit 5 written directly, divider 0
    nxt(); regWrite(2'd2, 16'd5);
    nxt(); rdAddr = 2'd2; expect_at(0, 6, 5, "R3");
    nxt(); cntEnable = 1'b1;
    expect_at(0, 4, 0, "R6");
    expect_at(1, 0, 0, "R6");
    expect_at(1, 4, 1, "R6");
    expect_at(3, 0, 2, "R1");
    expect_at(5, 1, 0, "R1");
    expect_at(6, 1, 1, "R3");
    expect_at(6, 2, 1, "R1");
    expect_at(7, 0, 0, "R1");
    expect_at(7, 3, 1, "R1");
    repeat (7) nxt();
    cntEnable = 1'b0;
    expect_at(3, 0, 1, "R6");
    repeat (3) nxt();

    // R8: flag clear rules and interrupt gating
    expect_at(0, 5, 0, "R8");
    nxt(); irqEnable = 1'b1; expect_at(0, 5, 1, "R8");
    nxt(); regWrite(2'd3, 16'd1); expect_at(1, 3, 1, "R8");
    nxt(); regWrite(2'd3, 16'd0); expect_at(1, 3, 0, "R8"); expect_at(1, 5, 0, "R8");

    // R2: staged divider takes effect only at the wrap
    nxt(); regWrite(2'd1, 16'd2);
    nxt(); rdAddr = 2'd1; expect_at(0, 6, 2, "R11");
    cntEnable = 1'b1;
    expect_at(2, 0, 2, "R2");
    expect_at(5, 1, 1, "R2");
    expect_at(6, 0, 0, "R2");
    expect_at(7, 4, 0, "R2");
    expect_at(8, 4, 1, "R2");
    expect_at(8, 0, 0, "R2");
    expect_at(9, 0, 1, "R2");
    repeat (9) nxt();
    cntEnable = 1'b0;

    // R3: staged wrap limit with preload enabled
    nxt(); regWrite(2'd3, 16'd0);
    nxt(); arPreload = 1'b1; regWrite(2'd2, 16'd3);
    nxt(); regWrite(2'd1, 16'd0);
    nxt(); rdAddr = 2'd2; expect_at(0, 6, 3, "R3");
    cntEnable = 1'b1;
    expect_at(12, 0, 5, "R3");
    expect_at(13, 1, 0, "R3");
    expect_at(14, 1, 1, "R3");
    expect_at(15, 3, 1, "R1");
    expect_at(17, 1, 0, "R3");
    expect_at(18, 1, 1, "R3");
    expect_at(19, 0, 0, "R3");
    repeat (19) nxt();
    cntEnable = 1'b0;

    // R5: restart with flag source restricted
    nxt(); updSource = 1'b1; regWrite(2'd3, 16'd0);
    nxt(); rdAddr = 2'd3; expect_at(0, 6, 0, "R11");
    updGen = 1'b1;
    expect_at(0, 2, 1, "R5");
    expect_at(1, 3, 0, "R5");
    expect_at(1, 0, 0, "R9");

    // R4: updates suppressed
    nxt(); regWrite(2'd0, 16'd9); expect_at(1, 0, 9, "R10");
    nxt(); regWrite(2'd2, 16'd7);
    nxt(); updDisable = 1'b1; updGen = 1'b1;
    expect_at(0, 2, 0, "R4");
    expect_at(1, 0, 0, "R4");
    nxt(); cntEnable = 1'b1;
    expect_at(4, 1, 1, "R4");
    expect_at(4, 2, 0, "R4");
    expect_at(5, 0, 0, "R4");
    expect_at(5, 3, 0, "R4");
    repeat (5) nxt();
    cntEnable = 1'b0;

    // R9/R10: restart coinciding with a wrap, write over a tick
    nxt(); updDisable = 1'b0; updSource = 1'b0;
    nxt(); cntEnable = 1'b1;
    expect_at(3, 1, 1, "R9");
    expect_at(3, 2, 1, "R9");
    expect_at(4, 0, 0, "R9");
    expect_at(4, 3, 1, "R9");
    repeat (3) nxt();
    updGen = 1'b1;
    repeat (2) nxt();
    regWrite(2'd0, 16'h0020);
    expect_at(1, 0, 16'h0020, "R10");
    expect_at(2, 0, 16'h0021, "R10");
    nxt(); nxt();
    cntEnable = 1'b0;
    expect_at(1, 0, 16'h0022, "R10");

    // R7: zero wrap limit blocks counting
    nxt(); arPreload = 1'b0; regWrite(2'd2, 16'd0);
    nxt(); cntEnable = 1'b1;
    expect_at(3, 1, 0, "R7");
    expect_at(4, 0, 16'h0022, "R7");
    repeat (4) nxt();
    cntEnable = 1'b0;
    repeat (3) nxt();

    while (q.size() > 0) begin
      nChecks++;
      nFails++;
      $display("FAIL %s: actual unchecked item expected checked", q[0].tag);
      void'(q.pop_front());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule